// File: doc/BRIEF.md
# PTP System Time Counter

This block keeps a free-running system time for IEEE 1588 timestamping. The time has two parts: a 32-bit seconds count and a 31-bit binary subseconds count. The subseconds roll over at 2^31, and each rollover carries into the seconds. The time advances only while the enable input is high. It can advance by one of two methods. The coarse method adds an 8-bit increment on every clock. The fine method adds a 32-bit addend to a phase accumulator on every clock, and applies the increment only on the cycles where that accumulator carries out.

A host drives the block through register-style command strobes. One command loads the time outright. Another adds a signed offset to the time or subtracts it, as one atomic step. Each command sets a busy flag that clears itself once the operation is done. A command that arrives while an interlocking flag is set is dropped. A target-time comparator can be armed. It raises a one-cycle interrupt when the time passes the target, and it disarms itself when it fires. A rising edge on an external event strobe copies the time into a snapshot register. Reading the snapshot clears its valid flag.

Top module: `ptp_clock_core`

## Requirements
- R1: While `cfg_enable` is low, the time holds its value whenever no command is being applied, and `ts_valid` reads 0 one cycle after `cfg_enable` drops.
- R2: An accepted `cmd_init` samples `upd_sec` and bits 30:0 of `upd_low`, and sets `init_busy` on the next edge. On the edge after that, the time becomes exactly the sampled value and `init_busy` clears. Bit 31 of `upd_low` is ignored for a load.
- R3: A `cmd_init` that arrives while `init_busy` is 1 is ignored: its values never reach the time.
- R4: An accepted `cmd_update` applies one cycle after `update_busy` is set. With `upd_low[31]`=0, it adds (`upd_sec`, `upd_low[30:0]`) to the time. With `upd_low[31]`=1, it subtracts them.
- R5: A `cmd_update` is accepted only when `init_busy` and `update_busy` are both 0. When both command strobes arrive in the same cycle, the load wins. `init_busy` and `update_busy` are never 1 together.
- R6: With `cfg_fine`=0 and enable high, the subseconds grow by `sub_incr` on every clock.
- R7: With `cfg_fine`=1 and enable high, `addend` is summed into a 32-bit accumulator on each clock. The subseconds grow by `sub_incr` only on the cycles where that sum carries out. With an addend of 2^30, this gives 2 increments in any 8 consecutive cycles.
- R8: The subseconds wrap in binary at 2^31 and carry one into the seconds. A subtract that goes below zero borrows one second. The seconds themselves wrap modulo 2^32.
- R9: While `tgt_armed` is 1 and the time is strictly greater than (`tgt_sec`, `tgt_sub`), the next edge pulses `tgt_irq` for exactly one cycle and clears `tgt_armed`. A time equal to the target does not fire. `cmd_tgt_arm` sets `tgt_armed`.
- R10: On the edge that samples a 0-to-1 transition of `evt_strobe`, the current time is copied into `snap_sec`/`snap_sub` and `snap_valid` is set. A strobe held high captures nothing more. A `snap_read` pulse clears `snap_valid`.
- R11: `ts_valid` becomes 1 when a load completes while `cfg_enable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Enables timekeeping |
| cfg_fine | input | 1 | 1 selects the fine advance method, 0 the coarse method |
| cmd_init | input | 1 | Strobe that requests a load of the time |
| cmd_update | input | 1 | Strobe that requests an add or subtract |
| cmd_tgt_arm | input | 1 | Strobe that arms the target-time compare |
| upd_sec | input | 32 | Seconds value used by load and update |
| upd_low | input | 32 | Bit 31 is the sign (1 = subtract), bits 30:0 are the subseconds |
| sub_incr | input | 8 | Subsecond increment per advance step |
| addend | input | 32 | Fine-method accumulator addend |
| tgt_sec | input | 32 | Target seconds |
| tgt_sub | input | 31 | Target subseconds |
| evt_strobe | input | 1 | External snapshot event |
| snap_read | input | 1 | Pulse that marks the snapshot as read |
| time_sec | output | 32 | Running seconds |
| time_sub | output | 31 | Running subseconds |
| ts_valid | output | 1 | Time has been loaded while enabled |
| init_busy | output | 1 | Load in progress |
| update_busy | output | 1 | Add/subtract in progress |
| tgt_armed | output | 1 | Target compare armed |
| tgt_irq | output | 1 | One-cycle target-reached pulse |
| snap_sec | output | 32 | Captured seconds |
| snap_sub | output | 31 | Captured subseconds |
| snap_valid | output | 1 | Snapshot holds unread data |

## Verification
The update arithmetic is tried with a table of load/offset pairs, run with the clock disabled so that only the command changes the time. The pairs cover a plain add, an add that crosses 2^31 in the subseconds, a subtract that borrows a second, a subtract that lands exactly on zero, and an add that wraps the seconds past 2^32. Together these pairs separate a correct binary carry and borrow from an off-by-one carry and from the sign bit being ignored. The coarse and fine methods are each run over a fixed number of cycles. The fine run uses an addend whose carries come out to an exact count in any window, so a method mix-up shows as a different sum. The remaining tests drive commands back to back to check the interlocks, and run target equal versus just-greater to check the strict compare.

// File: rtl/ptp_clk_pkg.sv
package ptp_clk_pkg;

    parameter int SEC_W = 32;
    parameter int SUB_W = 31;
    parameter int INC_W = 8;
    parameter int ACC_W = 32;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } ptp_time_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_ADJ  = 2'd2
    } ptp_op_e;

    // Add a seconds/subseconds offset; subseconds wrap at 2^SUB_W.
    function automatic ptp_time_t time_plus(ptp_time_t a, logic [SEC_W-1:0] s,
                                            logic [SUB_W-1:0] f);
        ptp_time_t r;
        logic [SUB_W:0] sum;
        sum   = {1'b0, a.sub} + {1'b0, f};
        r.sub = sum[SUB_W-1:0];
        r.sec = a.sec + s + SEC_W'(sum[SUB_W]);
        return r;
    endfunction

    // Subtract an offset; a subseconds underflow borrows one second.
    function automatic ptp_time_t time_minus(ptp_time_t a, logic [SEC_W-1:0] s,
                                             logic [SUB_W-1:0] f);
        ptp_time_t r;
        logic [SUB_W:0] dif;
        dif   = {1'b0, a.sub} - {1'b0, f};
        r.sub = dif[SUB_W-1:0];
        r.sec = a.sec - s - SEC_W'(dif[SUB_W]);
        return r;
    endfunction

    function automatic logic time_after(ptp_time_t a, ptp_time_t b);
        return (a.sec > b.sec) || ((a.sec == b.sec) && (a.sub > b.sub));
    endfunction

endpackage

// File: rtl/ptp_tick_gen.sv
module ptp_tick_gen
    import ptp_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             fine,
    input  logic [ACC_W-1:0] addend,
    output logic             step
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_sum;

    assign acc_sum = {1'b0, acc_q} + {1'b0, addend};

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (enable && fine)
            acc_q <= acc_sum[ACC_W-1:0];
    end

    always_comb begin
        if (!enable)
            step = 1'b0;
        else if (fine)
            step = acc_sum[ACC_W];
        else
            step = 1'b1;
    end
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
    import ptp_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             init_req,
    input  logic             adj_req,
    input  logic [SEC_W-1:0] val_sec,
    input  logic [SUB_W:0]   val_low,
    input  logic             step,
    input  logic [INC_W-1:0] incr,
    output ptp_time_t        now,
    output logic             init_busy,
    output logic             adj_busy,
    output logic             valid
);
    ptp_op_e          op_q;
    ptp_op_e          op_next;
    logic [SEC_W-1:0] hold_sec;
    logic [SUB_W-1:0] hold_sub;
    logic             hold_neg;
    ptp_time_t        hold_t;

    assign init_busy = (op_q == OP_LOAD);
    assign adj_busy  = (op_q == OP_ADJ);
    assign hold_t    = '{sec: hold_sec, sub: hold_sub};

    // Interlocks: load needs no load pending; adjust needs nothing pending.
    always_comb begin
        op_next = OP_IDLE;
        if (init_req && !init_busy)
            op_next = OP_LOAD;
        else if (adj_req && !init_busy && !adj_busy)
            op_next = OP_ADJ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now      <= '0;
            op_q     <= OP_IDLE;
            hold_sec <= '0;
            hold_sub <= '0;
            hold_neg <= 1'b0;
            valid    <= 1'b0;
        end else begin
            unique case (op_q)
                OP_LOAD: begin
                    now   <= hold_t;
                    valid <= enable;
                end
                OP_ADJ: begin
                    if (hold_neg)
                        now <= time_minus(now, hold_sec, hold_sub);
                    else
                        now <= time_plus(now, hold_sec, hold_sub);
                end
                default: begin
                    if (step)
                        now <= time_plus(now, '0, SUB_W'(incr));
                end
            endcase
            op_q <= op_next;
            if (op_next != OP_IDLE) begin
                hold_sec <= val_sec;
                hold_sub <= val_low[SUB_W-1:0];
                hold_neg <= val_low[SUB_W];
            end
            if (!enable)
                valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ptp_event_latch.sv
module ptp_event_latch
    import ptp_clk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  logic      rd,
    input  ptp_time_t now,
    output ptp_time_t held,
    output logic      held_valid
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q   <= 1'b0;
            held       <= '0;
            held_valid <= 1'b0;
        end else begin
            strobe_q <= strobe;
            if (strobe && !strobe_q) begin
                held       <= now;
                held_valid <= 1'b1;
            end else if (rd) begin
                held_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ptp_clock_core.sv
module ptp_clock_core
    import ptp_clk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             cfg_fine,
    input  logic             cmd_init,
    input  logic             cmd_update,
    input  logic             cmd_tgt_arm,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic [SUB_W:0]   upd_low,
    input  logic [INC_W-1:0] sub_incr,
    input  logic [ACC_W-1:0] addend,
    input  logic [SEC_W-1:0] tgt_sec,
    input  logic [SUB_W-1:0] tgt_sub,
    input  logic             evt_strobe,
    input  logic             snap_read,
    output logic [SEC_W-1:0] time_sec,
    output logic [SUB_W-1:0] time_sub,
    output logic             ts_valid,
    output logic             init_busy,
    output logic             update_busy,
    output logic             tgt_armed,
    output logic             tgt_irq,
    output logic [SEC_W-1:0] snap_sec,
    output logic [SUB_W-1:0] snap_sub,
    output logic             snap_valid
);
    logic      step;
    ptp_time_t now;
    ptp_time_t snap_t;
    ptp_time_t tgt_t;

    ptp_tick_gen u_tick (
        .clk    (clk),
        .rst    (rst),
        .enable (cfg_enable),
        .fine   (cfg_fine),
        .addend (addend),
        .step   (step)
    );

    ptp_time_core u_core (
        .clk       (clk),
        .rst       (rst),
        .enable    (cfg_enable),
        .init_req  (cmd_init),
        .adj_req   (cmd_update),
        .val_sec   (upd_sec),
        .val_low   (upd_low),
        .step      (step),
        .incr      (sub_incr),
        .now       (now),
        .init_busy (init_busy),
        .adj_busy  (update_busy),
        .valid     (ts_valid)
    );

    ptp_event_latch u_snap (
        .clk        (clk),
        .rst        (rst),
        .strobe     (evt_strobe),
        .rd         (snap_read),
        .now        (now),
        .held       (snap_t),
        .held_valid (snap_valid)
    );

    assign time_sec = now.sec;
    assign time_sub = now.sub;
    assign snap_sec = snap_t.sec;
    assign snap_sub = snap_t.sub;
    assign tgt_t    = '{sec: tgt_sec, sub: tgt_sub};

    // Target compare: firing has priority over a same-cycle re-arm.
    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_armed <= 1'b0;
            tgt_irq   <= 1'b0;
        end else begin
            tgt_irq <= 1'b0;
            if (tgt_armed && time_after(now, tgt_t)) begin
                tgt_irq   <= 1'b1;
                tgt_armed <= 1'b0;
            end else if (cmd_tgt_arm) begin
                tgt_armed <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ptp_clock_core_chk.sv
module ptp_clock_core_chk
    import ptp_clk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_enable,
    input logic             cfg_fine,
    input logic [INC_W-1:0] sub_incr,
    input logic             evt_strobe,
    input logic [SEC_W-1:0] time_sec,
    input logic [SUB_W-1:0] time_sub,
    input logic             ts_valid,
    input logic             init_busy,
    input logic             update_busy,
    input logic             tgt_armed,
    input logic             tgt_irq,
    input logic             snap_valid
);
    assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable && !init_busy && !update_busy) |=> ($stable(time_sec) && $stable(time_sub)));

    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !ts_valid);

    assert_load_selfclear_R2: assert property (@(posedge clk) disable iff (rst)
        init_busy |=> !init_busy);

    assert_adj_selfclear_R4: assert property (@(posedge clk) disable iff (rst)
        update_busy |=> !update_busy);

    assert_busy_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(init_busy && update_busy));

    assert_coarse_step_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && !cfg_fine && !init_busy && !update_busy &&
         (({1'b0, time_sub} + (SUB_W+1)'(sub_incr)) < (SUB_W+1)'(2**SUB_W)))
        |=> (time_sub == $past(time_sub) + SUB_W'($past(sub_incr))));

    assert_irq_disarms_R9: assert property (@(posedge clk) disable iff (rst)
        tgt_irq |-> ($past(tgt_armed) && !tgt_armed));

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
        tgt_irq |=> !tgt_irq);

    assert_snap_on_edge_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(snap_valid) |-> $past(evt_strobe));
endmodule

bind ptp_clock_core ptp_clock_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_enable  (cfg_enable),
    .cfg_fine    (cfg_fine),
    .sub_incr    (sub_incr),
    .evt_strobe  (evt_strobe),
    .time_sec    (time_sec),
    .time_sub    (time_sub),
    .ts_valid    (ts_valid),
    .init_busy   (init_busy),
    .update_busy (update_busy),
    .tgt_armed   (tgt_armed),
    .tgt_irq     (tgt_irq),
    .snap_valid  (snap_valid)
);

// File: tb/test_ptp_clock_core.sv
`timescale 1ns/1ps
module test_ptp_clock_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0, cfg_fine = 1'b0;
    logic        cmd_init = 1'b0, cmd_update = 1'b0, cmd_tgt_arm = 1'b0;
    logic [31:0] upd_sec = '0, upd_low = '0, addend = '0, tgt_sec = '0;
    logic [7:0]  sub_incr = '0;
    logic [30:0] tgt_sub = '0;
    logic        evt_strobe = 1'b0, snap_read = 1'b0;
    logic [31:0] time_sec, snap_sec;
    logic [30:0] time_sub, snap_sub;
    logic        ts_valid, init_busy, update_busy, tgt_armed, tgt_irq, snap_valid;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ptp_clock_core i_ptp_clock_core (.*);

    // {load sec, load low, offset sec, offset low (bit31 = subtract), exp sec, exp sub}
    localparam logic [191:0] VEC [6] = '{
        {32'd10,         32'd100,        32'd5, 32'h0000_0020, 32'd15, 32'd132},
        {32'd10,         32'h7FFF_FFF0,  32'd0, 32'h0000_0020, 32'd11, 32'h10},
        {32'd10,         32'h10,         32'd0, 32'h8000_0020, 32'd9,  32'h7FFF_FFF0},
        {32'd10,         32'h100,        32'd3, 32'h8000_0010, 32'd7,  32'hF0},
        {32'd0,          32'd5,          32'd0, 32'h8000_0005, 32'd0,  32'd0},
        {32'hFFFF_FFFF,  32'h7FFF_FFFF,  32'd0, 32'h0000_0001, 32'd0,  32'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe one command for one cycle; returns at the negedge after acceptance.
    task automatic issue(input bit is_load, input logic [31:0] s, input logic [31:0] l);
        @(negedge clk);
        upd_sec = s; upd_low = l;
        cmd_init = is_load; cmd_update = !is_load;
        @(negedge clk);
        cmd_init = 1'b0; cmd_update = 1'b0;
    endtask

    task automatic do_op(input bit is_load, input logic [31:0] s, input logic [31:0] l);
        issue(is_load, s, l);
        @(negedge clk);
    endtask

    function automatic logic [63:0] tnow();
        return {time_sec, 1'b0, time_sub};
    endfunction

    function automatic logic [63:0] tv(input logic [31:0] s, input logic [31:0] f);
        return {s, f};
    endfunction

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset time", tnow(), 64'd0);
        chk("reset flags", {60'd0, ts_valid, init_busy, update_busy, snap_valid}, 64'd0);

        // R4 / R8: table of load + offset cases with timekeeping off
        foreach (VEC[i]) begin
            do_op(1'b1, VEC[i][191:160], VEC[i][159:128]);
            do_op(1'b0, VEC[i][127:96], VEC[i][95:64]);
            chk("R4 R8 offset arithmetic", tnow(), VEC[i][63:0]);
        end

        // R2: busy for one cycle, sign bit ignored on load
        issue(1'b1, 32'd42, 32'h8000_0005);
        chk("R2 busy set", {63'd0, init_busy}, 64'd1);
        @(negedge clk);
        chk("R2 load value sign ignored", tnow(), tv(42, 5));
        chk("R2 busy cleared", {63'd0, init_busy}, 64'd0);

        // R3: second load while busy is dropped
        @(negedge clk);
        upd_sec = 32'd1; upd_low = 32'd1; cmd_init = 1'b1;
        @(negedge clk);
        upd_sec = 32'd7; upd_low = 32'd7;
        @(negedge clk);
        cmd_init = 1'b0;
        chk("R3 overlapping load ignored", tnow(), tv(1, 1));
        @(negedge clk);
        chk("R3 time still first load", tnow(), tv(1, 1));

        // R5: update during load busy is dropped
        @(negedge clk);
        upd_sec = 32'd20; upd_low = 32'd0; cmd_init = 1'b1;
        @(negedge clk);
        cmd_init = 1'b0; upd_sec = 32'd0; upd_low = 32'd5; cmd_update = 1'b1;
        @(negedge clk);
        cmd_update = 1'b0;
        @(negedge clk);
        chk("R5 update during load ignored", tnow(), tv(20, 0));
        chk("R5 no update busy", {63'd0, update_busy}, 64'd0);
        // R5: update during update busy is dropped
        @(negedge clk);
        upd_sec = 32'd0; upd_low = 32'd5; cmd_update = 1'b1;
        @(negedge clk);
        upd_low = 32'd100;
        @(negedge clk);
        cmd_update = 1'b0;
        @(negedge clk);
        chk("R5 overlapping update ignored", tnow(), tv(20, 5));
        // R5: both strobes together -> load wins
        @(negedge clk);
        upd_sec = 32'd30; upd_low = 32'd9; cmd_init = 1'b1; cmd_update = 1'b1;
        @(negedge clk);
        cmd_init = 1'b0; cmd_update = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R5 load wins over update", tnow(), tv(30, 9));

        // R6 / R11: coarse advance
        cfg_enable = 1'b1; cfg_fine = 1'b0; sub_incr = 8'd3;
        do_op(1'b1, 32'd1, 32'd0);
        chk("R11 valid after load", {63'd0, ts_valid}, 64'd1);
        chk("R6 loaded start", tnow(), tv(1, 0));
        repeat (4) @(negedge clk);
        chk("R6 coarse 4 steps", tnow(), tv(1, 12));
        // R8: coarse rollover
        do_op(1'b1, 32'd2, 32'h7FFF_FFFE);
        @(negedge clk);
        chk("R8 coarse rollover", tnow(), tv(3, 1));

        // R7: fine advance, addend 2^30 -> 2 carries per 8 cycles
        cfg_fine = 1'b1; addend = 32'h4000_0000; sub_incr = 8'd5;
        do_op(1'b1, 32'd0, 32'd0);
        repeat (8) @(negedge clk);
        chk("R7 fine 8 cycles", tnow(), tv(0, 10));

        // R1: disable suspends time and clears valid
        cfg_enable = 1'b0; cfg_fine = 1'b0;
        @(negedge clk);
        chk("R1 valid cleared", {63'd0, ts_valid}, 64'd0);
        begin
            logic [63:0] held_t;
            held_t = tnow();
            repeat (5) @(negedge clk);
            chk("R1 time frozen", tnow(), held_t);
        end

        // R9: target equal does not fire, greater fires once
        do_op(1'b1, 32'd100, 32'd50);
        tgt_sec = 32'd100; tgt_sub = 31'd50; cmd_tgt_arm = 1'b1;
        @(negedge clk);
        cmd_tgt_arm = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 equal no fire", {62'd0, tgt_armed, tgt_irq}, 64'd2);
        tgt_sub = 31'd49;
        @(negedge clk);
        chk("R9 fire and disarm", {62'd0, tgt_armed, tgt_irq}, 64'd1);
        @(negedge clk);
        chk("R9 single pulse", {62'd0, tgt_armed, tgt_irq}, 64'd0);

        // R10: snapshot on rising edge only
        evt_strobe = 1'b1;
        @(negedge clk);
        chk("R10 capture", {snap_sec, 1'b0, snap_sub}, tv(100, 50));
        chk("R10 valid set", {63'd0, snap_valid}, 64'd1);
        do_op(1'b1, 32'd200, 32'd0);
        chk("R10 held level no recapture", {snap_sec, 1'b0, snap_sub}, tv(100, 50));
        snap_read = 1'b1;
        @(negedge clk);
        snap_read = 1'b0;
        chk("R10 read clears valid", {63'd0, snap_valid}, 64'd0);
        evt_strobe = 1'b0;
        @(negedge clk);
        evt_strobe = 1'b1;
        @(negedge clk);
        evt_strobe = 1'b0;
        chk("R10 second capture", {snap_sec, 1'b0, snap_sub}, tv(200, 0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule